// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block is the device-side control for a byte-alterable parallel EEPROM. A free-running system clock samples the three active-low strobes: chip select (`ce_n`), output enable (`oe_n`) and write enable (`we_n`). It works out from them when a host is reading and when it is writing. Write cycles fill a page buffer one byte at a time. Once the host stops loading bytes, a timed programming phase runs and commits the buffered bytes into a small register array.

While programming runs, a read does not return stored data. It returns a status word: bit 7 holds the inverse of the top bit of the last byte loaded, and bit 6 changes value on every read. A host polls either bit to learn when programming has ended. A `lock` input blocks new writes. Any byte load aimed at a page other than the page being loaded is dropped, and this is recorded on a sticky `page_err` flag.

The byte-load window and the programming time are counted in system clocks. The array keeps `2**ROW_BITS` pages and selects them with the low page-address bits. Higher page bits still take part in the page-match check.

Top module: `pwe_sequencer`

## Requirements
- R1: `dq_drive` is high only while both `ce_n` and `oe_n` are low, two clocks after each of them is sampled. While it is low, `dq_out` is zero. After reset `dq_drive` is low.
- R2: A write cycle needs `ce_n` and `we_n` low with `oe_n` high. Strobing all three low stores nothing.
- R3: The byte address is taken when the later of the `ce_n`/`we_n` falling edges is seen. A change on `addr` before that edge does not matter.
- R4: The data byte is taken when the earlier of the `ce_n`/`we_n` rising edges is seen. A change on `din` after that edge does not matter, provided `din` stays stable for three clocks after it.
- R5: A page holds `2**OFF_W` bytes. The page is `addr[ADDR_W-1:OFF_W]` and the byte offset is `addr[OFF_W-1:0]`. All bytes loaded into one page are committed in a single programming phase. When the same offset is loaded twice, the later byte is kept.
- R6: A load whose page differs from the page being loaded is ignored, and it sets `page_err`. `page_err` stays set until reset.
- R7: Loading ends once `LOAD_WIN` clocks pass with no accepted write start and no write in progress. A write start within the window restarts it. Until loading ends, reads return the old array contents.
- R8: Programming lasts `PROG_CYC` clocks and then returns to idle. Write cycles issued during programming are ignored. After programming, reads return the new bytes.
- R9: During programming, a read returns `{~b7, t, 6'b000000}`, where `b7` is bit 7 of the last byte loaded and `t` is the toggle bit.
- R10: The toggle bit is 0 when programming starts and inverts at the start of each read during programming. The first read therefore shows 1.
- R11: While `lock` is high, no write is accepted from idle. No programming starts and no status word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address: page in the high bits, offset in the low bits |
| din | input | 8 | Write data from the host |
| lock | input | 1 | Protected mode: blocks new writes |
| dq_out | output | 8 | Read data or the status word |
| dq_drive | output | 1 | High while the data bus should be driven |
| page_err | output | 1 | Sticky flag for a dropped, page-mismatched load |

## Verification
The assertions assume that `addr` is stable from the strobe falling edge until it has been synchronised. They also assume that `din` is held for at least three clocks after the first strobe rising edge, since the bus is sampled only after the strobe has passed through the synchroniser. The bench drives every input on the falling clock edge. It holds address and data for at least four clocks around each strobe edge and keeps each active strobe phase at least five clocks long, so every edge is seen cleanly. Gaps between loads are kept well under the byte-load window, and waits meant to cross a window boundary go well past it. No sample is taken near an exact boundary cycle.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } seq_state_e;

    // Decoded strobe activity, all in the system-clock domain
    typedef struct packed {
        logic rd_act;
        logic rd_start;
        logic wr_act;
        logic wr_start;
        logic wr_end;
    } strobe_ev_t;

    // Status word returned by reads while programming is in progress
    function automatic logic [DATA_W-1:0] poll_word(input logic last_msb, input logic tog);
        return {~last_msb, tog, {(DATA_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/pwe_strobe_sync.sv
module pwe_strobe_sync
    import pwe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    output strobe_ev_t ev
);

    localparam int NSTROBE = 3;

    logic [NSTROBE-1:0] raw_v;
    logic [NSTROBE-1:0] sync_v;
    logic               wr_q, rd_q;
    logic               wr_now, rd_now;

    assign raw_v = {ce_n, oe_n, we_n};

    // One identical synchroniser chain per strobe
    for (genvar g = 0; g < NSTROBE; g++) begin : g_chain
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '1;
            else     q <= {q[STAGES-2:0], raw_v[g]};
        end
        assign sync_v[g] = q[STAGES-1];
    end

    // sync_v[2] = chip select, [1] = output enable, [0] = write enable
    assign wr_now = !sync_v[2] && !sync_v[0] && sync_v[1];
    assign rd_now = !sync_v[2] && !sync_v[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_now;
            rd_q <= rd_now;
        end
    end

    assign ev.wr_act   = wr_now;
    assign ev.wr_start = wr_now && !wr_q;
    assign ev.wr_end   = !wr_now && wr_q;
    assign ev.rd_act   = rd_now;
    assign ev.rd_start = rd_now && !rd_q;

endmodule

// File: rtl/pwe_page_loader.sv
module pwe_page_loader
    import pwe_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int OFF_W    = 8,
    parameter int LOAD_WIN = 10000,
    parameter int PROG_CYC = 500000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_start,
    input  logic                              wr_end,
    input  logic                              wr_act,
    input  logic                              rd_start,
    input  logic                              lock,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 din,
    output logic                              busy,
    output logic                              commit,
    output logic [ADDR_W-OFF_W-1:0]           page,
    output logic [(1<<OFF_W)-1:0][DATA_W-1:0] pbuf,
    output logic [(1<<OFF_W)-1:0]             pmask,
    output logic                              last_msb,
    output logic                              tog,
    output logic                              page_err
);

    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int WIN_W  = $clog2(LOAD_WIN + 1);
    localparam int PRG_W  = $clog2(PROG_CYC + 1);

    seq_state_e         state;
    logic [OFF_W-1:0]   off_q;
    logic               pending;
    logic [WIN_W-1:0]   win_cnt;
    logic [PRG_W-1:0]   prg_cnt;
    logic [PAGE_W-1:0]  wr_page;
    logic               store;
    logic               window_out;

    assign wr_page    = addr[ADDR_W-1:OFF_W];
    assign store      = pending && wr_end;
    assign window_out = (win_cnt >= WIN_W'(LOAD_WIN)) && !pending && !wr_act;
    assign busy       = (state == ST_PROG);
    assign commit     = busy && (prg_cnt == PRG_W'(PROG_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            page     <= '0;
            off_q    <= '0;
            pending  <= 1'b0;
            win_cnt  <= '0;
            prg_cnt  <= '0;
            pmask    <= '0;
            last_msb <= 1'b0;
            tog      <= 1'b0;
            page_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_start && !lock) begin
                        page    <= wr_page;
                        off_q   <= addr[OFF_W-1:0];
                        pending <= 1'b1;
                        win_cnt <= '0;
                        state   <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (win_cnt < WIN_W'(LOAD_WIN)) win_cnt <= win_cnt + 1'b1;
                    if (wr_start && !lock) begin
                        if (wr_page == page) begin
                            off_q   <= addr[OFF_W-1:0];
                            pending <= 1'b1;
                            win_cnt <= '0;
                        end else begin
                            page_err <= 1'b1;
                        end
                    end else if (window_out) begin
                        state   <= ST_PROG;
                        prg_cnt <= '0;
                        tog     <= 1'b0;
                    end
                end
                ST_PROG: begin
                    if (rd_start) tog <= ~tog;
                    if (commit) begin
                        state <= ST_IDLE;
                        pmask <= '0;
                    end else begin
                        prg_cnt <= prg_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (store) begin
                pmask[off_q] <= 1'b1;
                last_msb     <= din[DATA_W-1];
                pending      <= 1'b0;
            end
        end
    end

    // Buffer contents are qualified by pmask, so they need no reset
    always_ff @(posedge clk) begin
        if (store) pbuf[off_q] <= din;
    end

    // R8: no load can be open while programming
    a_r8_no_load_in_prog: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG) |-> !pending);

    // R6: the mismatch flag never clears on its own
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(page_err) |-> page_err);

    // R7: programming begins only after a full quiet window
    a_r7_full_window: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG && $past(state) == ST_LOAD) |-> $past(win_cnt) == WIN_W'(LOAD_WIN));

    // R10: each read start during programming inverts the toggle bit
    a_r10_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG && $past(state) == ST_PROG && $past(rd_start)) |-> tog != $past(tog));

    // R11: a locked write leaves the sequencer idle
    a_r11_locked_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && lock && wr_start) |=> state == ST_IDLE);

endmodule

// File: rtl/pwe_cell_array.sv
module pwe_cell_array
    import pwe_pkg::*;
#(
    parameter int OFF_W    = 8,
    parameter int ROW_BITS = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              commit,
    input  logic [ROW_BITS-1:0]               wr_row,
    input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] pbuf,
    input  logic [(1<<OFF_W)-1:0]             pmask,
    input  logic [ROW_BITS-1:0]               rd_row,
    input  logic [OFF_W-1:0]                  rd_off,
    output logic [DATA_W-1:0]                 rdata
);

    localparam int ROWS       = 1 << ROW_BITS;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam logic [DATA_W-1:0] ERASED = '1;

    logic [DATA_W-1:0] mem [ROWS][PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int i = 0; i < PAGE_BYTES; i++)
                    mem[r][i] <= ERASED;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (pmask[i]) mem[wr_row][i] <= pbuf[i];
        end
    end

    assign rdata = mem[rd_row][rd_off];

    // R8: stored bytes change only on the edge that follows a commit
    a_r8_hold_between_commits: assert property (@(posedge clk) disable iff (rst)
        (!$past(commit) && $past(rd_row) == rd_row && $past(rd_off) == rd_off)
        |-> rdata == $past(rdata));

endmodule

// File: rtl/pwe_sequencer.sv
module pwe_sequencer
    import pwe_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int OFF_W       = 8,
    parameter int ROW_BITS    = 1,
    parameter int SYNC_STAGES = 2,
    parameter int LOAD_WIN    = 10000,
    parameter int PROG_CYC    = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              lock,
    output logic [7:0]        dq_out,
    output logic              dq_drive,
    output logic              page_err
);

    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int PAGE_W     = ADDR_W - OFF_W;

    strobe_ev_t                         ev;
    logic                               busy, commit, last_msb, tog;
    logic [PAGE_W-1:0]                  page;
    logic [PAGE_BYTES-1:0][DATA_W-1:0]  pbuf;
    logic [PAGE_BYTES-1:0]              pmask;
    logic [DATA_W-1:0]                  rdata;

    pwe_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .ev   (ev)
    );

    pwe_page_loader #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .LOAD_WIN (LOAD_WIN),
        .PROG_CYC (PROG_CYC)
    ) u_loader (
        .clk      (clk),
        .rst      (rst),
        .wr_start (ev.wr_start),
        .wr_end   (ev.wr_end),
        .wr_act   (ev.wr_act),
        .rd_start (ev.rd_start),
        .lock     (lock),
        .addr     (addr),
        .din      (din),
        .busy     (busy),
        .commit   (commit),
        .page     (page),
        .pbuf     (pbuf),
        .pmask    (pmask),
        .last_msb (last_msb),
        .tog      (tog),
        .page_err (page_err)
    );

    pwe_cell_array #(
        .OFF_W    (OFF_W),
        .ROW_BITS (ROW_BITS)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .wr_row (page[ROW_BITS-1:0]),
        .pbuf   (pbuf),
        .pmask  (pmask),
        .rd_row (addr[OFF_W+ROW_BITS-1:OFF_W]),
        .rd_off (addr[OFF_W-1:0]),
        .rdata  (rdata)
    );

    assign dq_drive = ev.rd_act;
    assign dq_out   = !ev.rd_act ? '0 : (busy ? poll_word(last_msb, tog) : rdata);

    // R1: the bus is released whenever a strobe was seen high two clocks back
    a_r1_release_when_deselected: assert property (@(posedge clk) disable iff (rst)
        ($past(ce_n, 2) || $past(oe_n, 2)) |-> !dq_drive);

    // R1: nothing is presented while the bus is released
    a_r1_zero_when_released: assert property (@(posedge clk) disable iff (rst)
        !dq_drive |-> dq_out == '0);

endmodule

// File: tb/sim_pwe_sequencer.sv
module sim_pwe_sequencer;

    localparam int LOAD_WIN = 50;
    localparam int PROG_CYC = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic        lock = 1'b0;
    logic [7:0]  dq_out;
    logic        dq_drive, page_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    event      smp;

    always #5 clk = ~clk;

    pwe_sequencer #(
        .ADDR_W   (17),
        .OFF_W    (8),
        .ROW_BITS (1),
        .LOAD_WIN (LOAD_WIN),
        .PROG_CYC (PROG_CYC)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (din),
        .lock     (lock),
        .dq_out   (dq_out),
        .dq_drive (dq_drive),
        .page_err (page_err)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expectations as each read sample is announced
    initial begin
        forever begin
            exp_item_t it;
            @(smp);
            it = exp_q.pop_front();
            check({7'd0, dq_drive}, 8'd1, {it.tag, " drive"});
            check(dq_out, it.exp, it.tag);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        ce_n = 1'b0;
        oe_n = 1'b0;
        wait_cyc(5);
        exp_q.push_back('{exp: e, tag: tag});
        -> smp;
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
        wait_cyc(4);
        check({7'd0, dq_drive}, 8'd0, "R1 released after read");
    endtask

    // Write cycle controlled by write enable
    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        din  = d;
        oe_n = 1'b1;
        ce_n = 1'b0;
        we_n = 1'b0;
        wait_cyc(6);
        we_n = 1'b1;
        wait_cyc(4);
        ce_n = 1'b1;
        wait_cyc(2);
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);

        // R1, R6: reset state
        check({7'd0, dq_drive}, 8'd0, "R1 drive after reset");
        check({7'd0, page_err}, 8'd0, "R6 flag after reset");
        do_read(17'h00005, 8'hFF, "R1 erased read");

        // R5, R7: page load with a repeated offset
        do_write(17'h00010, 8'h11);
        wait_cyc(15);
        do_write(17'h00011, 8'h22);
        wait_cyc(15);
        do_write(17'h00012, 8'h83);
        wait_cyc(15);
        do_write(17'h00010, 8'h44);
        do_read(17'h00010, 8'hFF, "R7 still loading");
        wait_cyc(70);
        // R9, R10: last byte 0x44 has bit 7 clear
        do_read(17'h00010, 8'hC0, "R9 R10 first poll");
        do_read(17'h00012, 8'h80, "R10 second poll");
        do_read(17'h00011, 8'hC0, "R10 third poll");
        do_write(17'h00020, 8'h55);        // R8: ignored while programming
        wait_cyc(450);
        do_read(17'h00010, 8'h44, "R5 last load wins");
        do_read(17'h00011, 8'h22, "R5 second byte");
        do_read(17'h00012, 8'h83, "R5 third byte");
        do_read(17'h00020, 8'hFF, "R8 write during programming ignored");

        // R3, R4: cycle controlled by chip select
        @(negedge clk);
        oe_n = 1'b1;
        addr = 17'h00130;
        din  = 8'h5A;
        we_n = 1'b0;
        wait_cyc(5);
        addr = 17'h00131;
        wait_cyc(5);
        ce_n = 1'b0;
        wait_cyc(6);
        ce_n = 1'b1;
        wait_cyc(4);
        din = 8'hE7;
        wait_cyc(4);
        we_n = 1'b1;
        wait_cyc(70);
        do_read(17'h00131, 8'hC0, "R9 poll after chip-select write");
        wait_cyc(450);
        do_read(17'h00131, 8'h5A, "R3 R4 stored at later address, first data");
        do_read(17'h00130, 8'hFF, "R3 early address unused");

        // R6: page mismatch dropped and flagged
        do_write(17'h00040, 8'h11);
        wait_cyc(10);
        do_write(17'h00140, 8'h99);
        check({7'd0, page_err}, 8'd1, "R6 flag set");
        wait_cyc(600);
        do_read(17'h00040, 8'h11, "R6 matching byte stored");
        do_read(17'h00140, 8'hFF, "R6 mismatched byte dropped");
        check({7'd0, page_err}, 8'd1, "R6 flag sticky");

        // R2: all three strobes low stores nothing
        @(negedge clk);
        addr = 17'h00050;
        din  = 8'h77;
        ce_n = 1'b0;
        oe_n = 1'b0;
        we_n = 1'b0;
        wait_cyc(6);
        we_n = 1'b1;
        wait_cyc(4);
        ce_n = 1'b1;
        oe_n = 1'b1;
        wait_cyc(80);
        do_read(17'h00050, 8'hFF, "R2 no status after strobes with oe low");
        wait_cyc(450);
        do_read(17'h00050, 8'hFF, "R2 nothing stored");

        // R11: protected mode
        @(negedge clk);
        lock = 1'b1;
        do_write(17'h00060, 8'h33);
        wait_cyc(70);
        do_read(17'h00060, 8'hFF, "R11 no status when locked");
        wait_cyc(450);
        do_read(17'h00060, 8'hFF, "R11 nothing stored when locked");
        lock = 1'b0;

        wait_cyc(5);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule